// File: doc/BRIEF.md
# DRAM Row-Buffer Command Sequencer

This block turns 64-byte cache-block read and write requests into DRAM command sequences for one memory channel that carries two ranks on a 64-bit data bus. It splits each physical address into rank, bank, row and a column-block index. It keeps a record of the open row in every bank of both ranks. From that record it issues precharge, activate and column commands. The column commands move the block as eight 8-byte beats on consecutive cycles.

A static input selects the row policy. With the open-row policy, a row stays in its bank's row buffer after an access, so a later request to the same row needs only column commands. With the closed-row policy, every access ends with a precharge of its bank. Three parameters set the minimum cycle gaps between commands: precharge to activate, activate to first column command, and last column command to any later command. The block takes one request at a time. It holds ready low until the whole sequence for the current request has gone out.

Top module: `dram_row_sequencer`

## Requirements
- R1: The request address maps as follows. Bits [5:0] are a byte offset and are ignored. Bits [13:6] are the column-block index, bits [16:14] the bank, bits [30:17] the row and bit [31] the rank. Column commands put `{block index, beat}` on `dram_addr[10:0]`, and `dram_addr[13:11]` is zero for them. Activate puts the row on `dram_addr`.
- R2: Command codes are NOP=0, PRE=1, ACT=2, RD=3 and WR=4. For every command other than NOP, exactly one `dram_cs_n` bit is low, bit r for rank r. During NOP both bits are high.
- R3: A request to a bank with no open row issues ACT and then eight column commands. No PRE comes first.
- R4: Under the open-row policy, a request to the row already open in its bank issues only the eight column commands.
- R5: Under the open-row policy, a request to a bank that holds a different row issues PRE, then ACT of the new row, then the eight column commands, all to that bank.
- R6: Under the closed-row policy, the eight column commands are followed by a PRE to the same bank. A repeat request to that same row must therefore start with ACT again.
- R7: The eight column commands of a block fall on consecutive cycles, with low column bits 0 to 7 in order. On WR beat k, `dram_dq_out` carries `req_wdata[64k+63:64k]`, byte j on bits 8j+7:8j, and `dram_dq_oe` is high only during WR.
- R8: Each RD is followed one cycle later by `rsp_valid`, with `rsp_data` equal to `dram_dq_in` in the RD cycle. `rsp_last` is high only with the eighth beat.
- R9: A PRE is followed by ACT no sooner than T_RP cycles later. An ACT is followed by its first column command no sooner than T_RCD cycles later. The last column command of a block is followed by any other command no sooner than T_WR cycles later. These gaps also hold across requests.
- R10: `req_ready` is high when idle. It drops in the cycle after a request is accepted. It rises in the cycle right after the last command of that request: the eighth column command, or the closing PRE under the closed-row policy.
- R11: After reset, `req_ready` is high, the command is NOP, both chip selects are high, `rsp_valid` is low and no bank is open. The first access to any bank therefore starts with ACT.
- R12: Open rows are tracked for each bank of each rank separately. An access to the same bank number in the other rank leaves the first rank's open row in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| closed_policy | input | 1 | 1 selects the closed-row policy, 0 the open-row policy |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for a block write, 0 for a block read |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 512 | Write block, beat k in bits 64k+63:64k |
| rsp_valid | output | 1 | Read beat valid |
| rsp_data | output | 64 | Read beat data |
| rsp_last | output | 1 | Eighth read beat |
| dram_cmd | output | 3 | Command code |
| dram_cs_n | output | 2 | Active-low rank selects |
| dram_bank | output | 3 | Bank address |
| dram_addr | output | 14 | Row or column address |
| dram_dq_out | output | 64 | Write data toward the devices |
| dram_dq_oe | output | 1 | Write data drive enable |
| dram_dq_in | input | 64 | Read data from the devices |

## Verification
The sequencer is driven with four access patterns:

- An access to an empty bank checks that the sequence starts with ACT and has no PRE.
- A repeat of the open row checks that only column commands are issued.
- A different row in the same bank checks the PRE-ACT prefix.
- The same bank number in the other rank checks that open rows are tracked per rank and per bank.

Back-to-back hits check the gap from the last column command of one block to the first of the next. Under the closed-row policy, a repeat of the same row checks that ACT comes back and that the PRE-to-ACT gap holds across requests. A row still open from open-policy traffic shows whether the policy switch starts from the recorded row state. Reads are checked beat by beat against data that encodes each beat's bank and column. Writes are checked lane by lane against the supplied block.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    localparam int RANK_W = 1;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;
    localparam int COL_W  = 11;
    localparam int OFS_W  = 6;
    localparam int BEAT_W = 3;
    localparam int CBLK_W = COL_W - BEAT_W;
    localparam int ADDR_W = OFS_W + CBLK_W + BANK_W + ROW_W + RANK_W;
    localparam int BEATS  = 1 << BEAT_W;
    localparam int NRANK  = 1 << RANK_W;
    localparam int DQ_W   = 64;
    localparam int BLK_W  = DQ_W * BEATS;
    localparam int IDX_W  = RANK_W + BANK_W;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_CLOSE
    } seq_st_e;

    // field order follows the address bits from high to low
    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [CBLK_W-1:0] cblk;
    } loc_t;

    function automatic loc_t split_addr(input logic [ADDR_W-1:0] a);
        return loc_t'(a[ADDR_W-1:OFS_W]);
    endfunction

    function automatic logic [IDX_W-1:0] bank_idx(input loc_t l);
        return {l.rank, l.bank};
    endfunction
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split
    import dram_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output loc_t              loc
);
    always_comb loc = split_addr(addr);
endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker
    import dram_seq_pkg::*;
#(
    parameter int N_IDX_W = IDX_W,
    parameter int N_ROW_W = ROW_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_IDX_W-1:0] lk_idx,
    input  logic [N_ROW_W-1:0] lk_row,
    output logic               lk_open,
    output logic               lk_hit,
    input  logic               upd_pre,
    input  logic               upd_act,
    input  logic [N_IDX_W-1:0] upd_idx,
    input  logic [N_ROW_W-1:0] upd_row
);
    localparam int NB = 1 << N_IDX_W;

    logic [NB-1:0]      vld;
    logic [N_ROW_W-1:0] rows [NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            for (int e = 0; e < NB; e++) begin
                if (upd_idx == N_IDX_W'(e)) begin
                    if (upd_pre) begin
                        vld[e] <= 1'b0;
                    end else if (upd_act) begin
                        vld[e]  <= 1'b1;
                        rows[e] <= upd_row;
                    end
                end
            end
        end
    end

    assign lk_open = vld[lk_idx];
    assign lk_hit  = vld[lk_idx] && (rows[lk_idx] == lk_row);

    // R11: reset leaves every bank without an open row
    a_r11_reset_clear: assert property (@(posedge clk) rst |=> (vld == '0));
    // R12: one bank record changes per cycle at most
    a_r12_one_update: assert property (@(posedge clk) disable iff (rst)
        !(upd_pre && upd_act));
    // R5: a precharge leaves its bank closed
    a_r5_pre_closes: assert property (@(posedge clk) disable iff (rst)
        upd_pre |=> !vld[$past(upd_idx)]);
endmodule

// File: rtl/dram_row_sequencer.sv
module dram_row_sequencer
    import dram_seq_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RCD = 3,
    parameter int T_WR  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               closed_policy,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BLK_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic [DQ_W-1:0]    rsp_data,
    output logic               rsp_last,
    output logic [2:0]         dram_cmd,
    output logic [NRANK-1:0]   dram_cs_n,
    output logic [BANK_W-1:0]  dram_bank,
    output logic [ROW_W-1:0]   dram_addr,
    output logic [DQ_W-1:0]    dram_dq_out,
    output logic               dram_dq_oe,
    input  logic [DQ_W-1:0]    dram_dq_in
);
    localparam int GAP_W = $clog2(T_RP + T_RCD + T_WR + 1);

    seq_st_e           state;
    loc_t              in_loc, cur, lk_loc;
    logic              cur_wr;
    logic [BLK_W-1:0]  wblk;
    logic [BEAT_W-1:0] beat;
    logic [GAP_W-1:0]  gap;
    logic              lk_open, lk_hit, issue;
    cmd_e              cmd;

    dram_addr_split u_split (.addr(req_addr), .loc(in_loc));

    assign lk_loc = (state == ST_IDLE) ? in_loc : cur;

    assign issue = (gap == '0) && (state != ST_IDLE);

    always_comb begin
        unique case (state)
            ST_PRE, ST_CLOSE: cmd = CMD_PRE;
            ST_ACT:           cmd = CMD_ACT;
            ST_COL:           cmd = cur_wr ? CMD_WR : CMD_RD;
            default:          cmd = CMD_NOP;
        endcase
        if (!issue) cmd = CMD_NOP;
    end

    dram_row_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .lk_idx (bank_idx(lk_loc)),
        .lk_row (lk_loc.row),
        .lk_open(lk_open),
        .lk_hit (lk_hit),
        .upd_pre(cmd == CMD_PRE),
        .upd_act(cmd == CMD_ACT),
        .upd_idx(bank_idx(cur)),
        .upd_row(cur.row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            gap    <= '0;
            beat   <= '0;
            cur    <= '0;
            cur_wr <= 1'b0;
            wblk   <= '0;
        end else begin
            if (gap != '0) gap <= gap - 1'b1;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    cur    <= in_loc;
                    cur_wr <= req_write;
                    wblk   <= req_wdata;
                    beat   <= '0;
                    state  <= lk_hit ? ST_COL : (lk_open ? ST_PRE : ST_ACT);
                end
                ST_PRE: if (gap == '0) begin
                    gap   <= GAP_W'(T_RP - 1);
                    state <= ST_ACT;
                end
                ST_ACT: if (gap == '0) begin
                    gap   <= GAP_W'(T_RCD - 1);
                    state <= ST_COL;
                end
                ST_COL: if (gap == '0) begin
                    beat <= beat + 1'b1;
                    if (beat == BEAT_W'(BEATS - 1)) begin
                        gap   <= GAP_W'(T_WR - 1);
                        state <= closed_policy ? ST_CLOSE : ST_IDLE;
                    end
                end
                ST_CLOSE: if (gap == '0) begin
                    gap   <= GAP_W'(T_RP - 1);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (cmd == CMD_RD);
            rsp_last  <= (cmd == CMD_RD) && (beat == BEAT_W'(BEATS - 1));
            rsp_data  <= dram_dq_in;
        end
    end

    assign req_ready   = (state == ST_IDLE);
    assign dram_cmd    = cmd;
    assign dram_cs_n   = (cmd == CMD_NOP) ? '1 : ~(NRANK'(1) << cur.rank);
    assign dram_bank   = cur.bank;
    assign dram_addr   = (state == ST_COL) ? ROW_W'({cur.cblk, beat}) : cur.row;
    assign dram_dq_oe  = (cmd == CMD_WR);
    assign dram_dq_out = dram_dq_oe ? wblk[int'(beat)*DQ_W +: DQ_W] : '0;

    // gap checkers: cycles since the last command of each kind, saturating
    logic [7:0] since_pre, since_act, since_col;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre <= '1;
            since_act <= '1;
            since_col <= '1;
        end else begin
            since_pre <= (cmd == CMD_PRE) ? 8'd1 : (since_pre == '1 ? since_pre : since_pre + 1'b1);
            since_act <= (cmd == CMD_ACT) ? 8'd1 : (since_act == '1 ? since_act : since_act + 1'b1);
            since_col <= (cmd == CMD_RD || cmd == CMD_WR) ? 8'd1
                       : (since_col == '1 ? since_col : since_col + 1'b1);
        end
    end

    a_r9_pre_to_act: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == CMD_ACT) |-> (since_pre >= 8'(T_RP)));
    a_r9_act_to_col: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == CMD_RD || dram_cmd == CMD_WR) |-> (since_act >= 8'(T_RCD)));
    a_r9_col_to_pre: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == CMD_PRE || dram_cmd == CMD_ACT) |-> (since_col >= 8'(T_WR)));
    a_r2_cs_one_rank: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd != CMD_NOP) |-> ($countones(~dram_cs_n) == 1));
    a_r2_cs_idle: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == CMD_NOP) |-> (dram_cs_n == '1));
    a_r7_beats_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (($past(dram_cmd) == CMD_RD || $past(dram_cmd) == CMD_WR)
         && $past(dram_addr[BEAT_W-1:0]) != BEAT_W'(BEATS - 1))
        |-> (dram_cmd == $past(dram_cmd)));
    a_r10_ready_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> ($past(dram_cmd) == CMD_PRE || $past(dram_cmd) == CMD_RD
                              || $past(dram_cmd) == CMD_WR));
    a_r3_act_only_closed_bank: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == CMD_ACT) |-> !lk_open);
endmodule

// File: tb/test_dram_row_sequencer.sv
module test_dram_row_sequencer;
    localparam int T_RP  = 3;
    localparam int T_RCD = 3;
    localparam int T_WR  = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         closed_policy = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [511:0] req_wdata = '0;
    logic         rsp_valid;
    logic [63:0]  rsp_data;
    logic         rsp_last;
    logic [2:0]   dram_cmd;
    logic [1:0]   dram_cs_n;
    logic [2:0]   dram_bank;
    logic [13:0]  dram_addr;
    logic [63:0]  dram_dq_out;
    logic         dram_dq_oe;
    logic [63:0]  dram_dq_in;

    always #2 clk = ~clk;

    assign dram_dq_in = 64'hF00D_CAFE_0000_0000 | {47'b0, dram_bank, dram_addr};

    dram_row_sequencer #(.T_RP(T_RP), .T_RCD(T_RCD), .T_WR(T_WR)) i_dram_row_sequencer (
        .clk(clk), .rst(rst), .closed_policy(closed_policy),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .dram_cmd(dram_cmd), .dram_cs_n(dram_cs_n), .dram_bank(dram_bank),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // command, response and ready-rise logs filled at the falling edge
    int          n_log = 0, n_rsp = 0, n_rise = 0;
    int          lg_cyc [256];
    logic [2:0]  lg_cmd [256];
    logic [1:0]  lg_cs  [256];
    logic [2:0]  lg_bank[256];
    logic [13:0] lg_addr[256];
    logic [63:0] lg_dq  [256];
    logic        lg_oe  [256];
    int          rs_cyc [256];
    logic [63:0] rs_data[256];
    logic        rs_last[256];
    int          rise_cyc[256];
    logic        prev_ready = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (dram_cmd != 3'd0 && n_log < 256) begin
                lg_cyc[n_log] = cyc;  lg_cmd[n_log] = dram_cmd; lg_cs[n_log] = dram_cs_n;
                lg_bank[n_log] = dram_bank; lg_addr[n_log] = dram_addr;
                lg_dq[n_log] = dram_dq_out; lg_oe[n_log] = dram_dq_oe;
                n_log++;
            end else if (dram_cmd == 3'd0 && dram_dq_oe) begin
                n_cmp++; n_bad++;
                $display("FAIL R7 dq_oe during NOP: actual 1 expected 0");
            end
            if (rsp_valid && n_rsp < 256) begin
                rs_cyc[n_rsp] = cyc; rs_data[n_rsp] = rsp_data; rs_last[n_rsp] = rsp_last;
                n_rsp++;
            end
            if (req_ready && !prev_ready && n_rise < 256) begin
                rise_cyc[n_rise] = cyc;
                n_rise++;
            end
            prev_ready = req_ready;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int rank, input int bank, input int row,
                                            input int cblk, input int ofs);
        return {rank[0], row[13:0], bank[2:0], cblk[7:0], ofs[5:0]};
    endfunction

    function automatic logic [511:0] mk_blk(input int seed);
        logic [511:0] b;
        for (int k = 0; k < 8; k++) b[k*64 +: 64] = 64'hC0DE_0000_0000_0000 | (64'(seed) << 16) | 64'(k);
        return b;
    endfunction

    task automatic do_req(input bit wr, input logic [31:0] a, input logic [511:0] blk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = blk;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = '0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // checks one request's commands starting at log entry st and read beats at rsp entry rst_i
    task automatic check_seq(input string tag, input int st, input int rst_i,
                             input bit pre, input bit act, input bit close, input bit wr,
                             input int rank, input int bank, input int row, input int cblk,
                             input logic [511:0] blk);
        int n_exp = int'(pre) + int'(act) + 8 + int'(close);
        int i = st;
        int first_col;
        bit rise_ok = 0;
        chk(n_log >= st + n_exp, tag, "command count", 64'(n_log - st), 64'(n_exp));
        if (n_log < st + n_exp) return;
        if (i > 0) begin
            if (lg_cmd[i-1] == 3'd3 || lg_cmd[i-1] == 3'd4)
                chk(lg_cyc[i] - lg_cyc[i-1] >= T_WR, "R9", "gap after previous block",
                    64'(lg_cyc[i] - lg_cyc[i-1]), 64'(T_WR));
            if (lg_cmd[i-1] == 3'd1 && lg_cmd[i] == 3'd2)
                chk(lg_cyc[i] - lg_cyc[i-1] >= T_RP, "R9", "PRE to ACT across requests",
                    64'(lg_cyc[i] - lg_cyc[i-1]), 64'(T_RP));
        end
        for (int k = st; k < st + n_exp; k++) begin
            chk(lg_cs[k] == ~(2'b01 << rank), "R2", "chip select", 64'(lg_cs[k]), 64'(~(2'b01 << rank)));
            chk(lg_bank[k] == 3'(bank), "R1", "bank", 64'(lg_bank[k]), 64'(bank));
        end
        if (pre) begin
            chk(lg_cmd[i] == 3'd1, "R5", {tag, " leading PRE"}, 64'(lg_cmd[i]), 64'd1);
            i++;
        end
        if (act) begin
            chk(lg_cmd[i] == 3'd2, tag, "ACT", 64'(lg_cmd[i]), 64'd2);
            chk(lg_addr[i] == 14'(row), "R1", "ACT row", 64'(lg_addr[i]), 64'(row));
            if (pre) chk(lg_cyc[i] - lg_cyc[i-1] >= T_RP, "R9", "PRE to ACT",
                         64'(lg_cyc[i] - lg_cyc[i-1]), 64'(T_RP));
            i++;
        end
        first_col = i;
        if (act) chk(lg_cyc[i] - lg_cyc[i-1] >= T_RCD, "R9", "ACT to column",
                     64'(lg_cyc[i] - lg_cyc[i-1]), 64'(T_RCD));
        for (int b = 0; b < 8; b++) begin
            chk(lg_cmd[i] == (wr ? 3'd4 : 3'd3), tag, "column command", 64'(lg_cmd[i]), wr ? 64'd4 : 64'd3);
            chk(lg_addr[i] == 14'({cblk[7:0], b[2:0]}), "R1", "column address",
                64'(lg_addr[i]), 64'({cblk[7:0], b[2:0]}));
            if (b > 0) chk(lg_cyc[i] == lg_cyc[i-1] + 1, "R7", "beats consecutive",
                           64'(lg_cyc[i] - lg_cyc[i-1]), 64'd1);
            chk(lg_oe[i] == wr, "R7", "dq_oe", 64'(lg_oe[i]), 64'(wr));
            if (wr) chk(lg_dq[i] == blk[b*64 +: 64], "R7", "write beat data", lg_dq[i], blk[b*64 +: 64]);
            i++;
        end
        if (close) begin
            chk(lg_cmd[i] == 3'd1, "R6", "closing PRE", 64'(lg_cmd[i]), 64'd1);
            chk(lg_cyc[i] - lg_cyc[i-1] >= T_WR, "R9", "column to closing PRE",
                64'(lg_cyc[i] - lg_cyc[i-1]), 64'(T_WR));
            i++;
        end
        for (int r = 0; r < n_rise; r++) if (rise_cyc[r] == lg_cyc[i-1] + 1) rise_ok = 1;
        chk(rise_ok, "R10", "ready rises after last command", 64'(rise_ok), 64'd1);
        if (!wr) begin
            chk(n_rsp >= rst_i + 8, "R8", "read beat count", 64'(n_rsp - rst_i), 64'd8);
            if (n_rsp >= rst_i + 8) begin
                for (int b = 0; b < 8; b++) begin
                    logic [63:0] e = 64'hF00D_CAFE_0000_0000 | {47'b0, 3'(bank), 3'b0, cblk[7:0], b[2:0]};
                    chk(rs_cyc[rst_i+b] == lg_cyc[first_col+b] + 1, "R8", "read beat timing",
                        64'(rs_cyc[rst_i+b]), 64'(lg_cyc[first_col+b] + 1));
                    chk(rs_data[rst_i+b] == e, "R8", "read beat data", rs_data[rst_i+b], e);
                    chk(rs_last[rst_i+b] == (b == 7), "R8", "last flag", 64'(rs_last[rst_i+b]), 64'(b == 7));
                end
            end
        end
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R11", "ready after reset", 64'(req_ready), 64'd1);
        chk(dram_cmd == 3'd0, "R11", "cmd after reset", 64'(dram_cmd), 64'd0);
        chk(dram_cs_n == 2'b11, "R11", "cs_n after reset", 64'(dram_cs_n), 64'd3);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_open_basic();
        int s, r;
        s = n_log; r = n_rsp;
        do_req(0, mk_addr(0, 2, 'h155, 'h12, 0), '0); settle();
        check_seq("R3", s, r, 0, 1, 0, 0, 0, 2, 'h155, 'h12, '0);
        s = n_log; r = n_rsp;
        do_req(1, mk_addr(0, 2, 'h155, 'h40, 0), mk_blk(1)); settle();
        check_seq("R4", s, r, 0, 0, 0, 1, 0, 2, 'h155, 'h40, mk_blk(1));
        s = n_log; r = n_rsp;
        do_req(0, mk_addr(0, 2, 'h2AA, 'h03, 0), '0); settle();
        check_seq("R5", s, r, 1, 1, 0, 0, 0, 2, 'h2AA, 'h03, '0);
    endtask

    task automatic t_rank_independent();
        int s, r;
        s = n_log; r = n_rsp;
        do_req(0, mk_addr(1, 2, 'h111, 'h07, 0), '0); settle();
        check_seq("R12", s, r, 0, 1, 0, 0, 1, 2, 'h111, 'h07, '0);
        s = n_log; r = n_rsp;
        do_req(0, mk_addr(0, 2, 'h2AA, 'hFF, 0), '0); settle();
        check_seq("R12", s, r, 0, 0, 0, 0, 0, 2, 'h2AA, 'hFF, '0);
    endtask

    task automatic t_back_to_back();
        int s1, s2, r2;
        s1 = n_log;
        do_req(1, mk_addr(0, 2, 'h2AA, 'h10, 0), mk_blk(2));
        s2 = n_log + 0; r2 = n_rsp;
        // s2 is fixed once the first block has fully issued
        do_req(0, mk_addr(0, 2, 'h2AA, 'h11, 'h3F), '0); settle();
        s2 = s1 + 8;
        check_seq("R4", s1, 0, 0, 0, 0, 1, 0, 2, 'h2AA, 'h10, mk_blk(2));
        check_seq("R4", s2, r2, 0, 0, 0, 0, 0, 2, 'h2AA, 'h11, '0);
    endtask

    task automatic t_closed();
        int s1, s2, r2;
        @(negedge clk); closed_policy = 1'b1;
        s1 = n_log;
        do_req(1, mk_addr(1, 5, 'h3FFF, 'h80, 'h21), mk_blk(3));
        r2 = n_rsp;
        do_req(0, mk_addr(1, 5, 'h3FFF, 'h80, 0), '0); settle();
        s2 = s1 + 10;
        check_seq("R6", s1, 0, 0, 1, 1, 1, 1, 5, 'h3FFF, 'h80, mk_blk(3));
        check_seq("R6", s2, r2, 0, 1, 1, 0, 1, 5, 'h3FFF, 'h80, '0);
        s1 = n_log; r2 = n_rsp;
        do_req(0, mk_addr(0, 2, 'h2AA, 'h21, 0), '0); settle();
        check_seq("R6", s1, r2, 0, 0, 1, 0, 0, 2, 'h2AA, 'h21, '0);
        s1 = n_log; r2 = n_rsp;
        do_req(0, mk_addr(0, 2, 'h2AA, 'h22, 0), '0); settle();
        check_seq("R6", s1, r2, 0, 1, 1, 0, 0, 2, 'h2AA, 'h22, '0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_open_basic();
        t_rank_independent();
        t_back_to_back();
        t_closed();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end
endmodule